// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Events

This block holds two 64-byte queues behind a small parallel register port. One queue carries bytes from a host controller toward a modem datapath (transmit). The other carries bytes from the modem back to the host (receive). Both queues share a single register address, `FIFO_ADDR` (7Fh). A write strobe to that address loads the transmit queue, and a read strobe from it unloads the receive queue. The modem side uses plain strobes: `tx_pop` takes the transmit head byte, and `rx_push` loads a receive byte.

Each queue watches its fill level against programmable byte thresholds. The transmit side has an almost-full limit and an almost-empty limit. The receive side has an almost-full limit. When the level moves across a limit, the block raises a one-cycle event. That event sets a sticky status bit, and `irq` stays high while any status bit is set. The host reads the status from `STAT_ADDR` (05h), and that read clears the bits. A clear command empties both queues at once.

Top module: `byte_queue_pair`

## Requirements
- R1: Each queue holds up to 64 bytes. After reset both levels are 0, `reg_rdata` is 00h, no status bit is set and `irq` is low.
- R2: A write strobe with `reg_addr`=7Fh appends `reg_wdata` to the transmit queue. `tx_head` shows the oldest byte, and each `tx_pop` removes one byte in write order. A push and a pop in the same cycle both take effect.
- R3: A read strobe with `reg_addr`=7Fh removes the oldest receive byte and presents it on `reg_rdata` from the following cycle, in push order.
- R4: A write to 7Fh while the transmit queue holds 64 bytes is dropped and sets status bit 3 (transmit overflow).
- R5: A read from 7Fh while the receive queue is empty returns 00h and sets status bit 4 (receive underflow).
- R6: When the transmit level goes from at most `tx_af_thr` to above it, status bit 0 is set.
- R7: When the transmit level goes from at least `tx_ae_thr` to below it, status bit 1 is set.
- R8: When the receive level goes from at most `rx_af_thr` to above it, status bit 2 is set.
- R9: A level that stays beyond a threshold raises no further event. Only a new crossing does.
- R10: A read strobe with `reg_addr`=05h returns {3'b000, status} on the next cycle and clears the status. An event in the same cycle as the read still sets its bit. `irq` is high exactly while the status is nonzero.
- R11: `fifo_clr` empties both queues in one cycle. It raises no threshold event and leaves the status unchanged.
- R12: An `rx_push` while the receive queue holds 64 bytes is dropped. A `tx_pop` on an empty transmit queue has no effect.
- R13: Writes to any address other than 7Fh change nothing. Reads from any address other than 7Fh and 05h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_clr | input | 1 | Empties both queues |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| tx_af_thr | input | 6 | Transmit almost-full limit, bytes |
| tx_ae_thr | input | 6 | Transmit almost-empty limit, bytes |
| rx_af_thr | input | 6 | Receive almost-full limit, bytes |
| tx_pop | input | 1 | Modem takes the transmit head byte |
| tx_head | output | 8 | Oldest transmit byte |
| tx_level | output | 7 | Transmit fill level |
| rx_push | input | 1 | Modem delivers a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_level | output | 7 | Receive fill level |
| irq | output | 1 | High while any status bit is set |

## Verification
Some properties are checked on every cycle. The levels never pass 64, and a clear empties a queue on the next cycle. A rising event is always followed by a higher level, and a falling event by a lower one. An event sets its sticky bit, and that bit stays set until a status read. A dropped write leaves the level alone, and an underflow read returns 00h.

Other behaviour only the bench scenarios can show. That covers byte order through both queues and the exact cycle each threshold is crossed. It also covers the absence of repeated events while a level stays beyond a limit. Finally, it covers the set-wins case when an event and a status read fall in the same cycle, and the silence of writes and reads at other addresses.

// File: rtl/byte_queue_pkg.sv
package byte_queue_pkg;
  localparam int unsigned EV_TX_AF  = 0;
  localparam int unsigned EV_TX_AE  = 1;
  localparam int unsigned EV_RX_AF  = 2;
  localparam int unsigned EV_TX_OVF = 3;
  localparam int unsigned EV_RX_UNF = 4;
  localparam int unsigned EV_W      = 5;

  // level moved from at-or-below the limit to above it
  function automatic logic crossed_up(input int unsigned was, input int unsigned now,
                                      input int unsigned lim);
    return (was <= lim) && (now > lim);
  endfunction

  // level moved from at-or-above the limit to below it
  function automatic logic crossed_down(input int unsigned was, input int unsigned now,
                                        input int unsigned lim);
    return (was >= lim) && (now < lim);
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] nxt_level,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rd_ptr];

  always_comb begin
    if (clr) nxt_level = '0;
    else     nxt_level = level + LVL_W'(push_ok) - LVL_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      level <= nxt_level;
    end
  end

  // R1
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  // R11
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> level == '0);
endmodule

// File: rtl/lvl_cross.sv
module lvl_cross
  import byte_queue_pkg::*;
#(
  parameter int unsigned LVL_W  = 7,
  parameter int unsigned THR_W  = 6,
  parameter bit          RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [LVL_W-1:0] nxt_lvl,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  generate
    if (RISING) begin : g_up
      assign hit = en && crossed_up(32'(cur_lvl), 32'(nxt_lvl), 32'(thr));
      // R6 R8
      up_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cur_lvl > $past(cur_lvl));
    end else begin : g_dn
      assign hit = en && crossed_down(32'(cur_lvl), 32'(nxt_lvl), 32'(thr));
      // R7
      down_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cur_lvl < $past(cur_lvl));
    end
  endgenerate
endmodule

// File: rtl/byte_queue_pair.sv
module byte_queue_pair
  import byte_queue_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned ADDR_W    = 7,
  parameter logic [6:0]  FIFO_ADDR = 7'h7F,
  parameter logic [6:0]  STAT_ADDR = 7'h05,
  localparam int unsigned THR_W    = $clog2(DEPTH),
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [THR_W-1:0]  tx_af_thr,
  input  logic [THR_W-1:0]  tx_ae_thr,
  input  logic [THR_W-1:0]  rx_af_thr,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_head,
  output logic [LVL_W-1:0]  tx_level,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_data,
  output logic [LVL_W-1:0]  rx_level,
  output logic              irq
);
  logic             fifo_wr, fifo_rd, stat_rd;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0] tx_nxt, rx_nxt;
  logic [DW-1:0]    rx_head;
  logic             tx_af_evt, tx_ae_evt, rx_af_evt, tx_ovf_evt, rx_unf_evt;
  logic [EV_W-1:0]  evts, stat;

  assign fifo_wr = reg_wr && (reg_addr == ADDR_W'(FIFO_ADDR));
  assign fifo_rd = reg_rd && (reg_addr == ADDR_W'(FIFO_ADDR));
  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(fifo_clr), .push(fifo_wr), .din(reg_wdata), .pop(tx_pop),
    .head(tx_head), .level(tx_level), .nxt_level(tx_nxt), .full(tx_full), .empty(tx_empty));

  byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(fifo_clr), .push(rx_push), .din(rx_data), .pop(fifo_rd),
    .head(rx_head), .level(rx_level), .nxt_level(rx_nxt), .full(rx_full), .empty(rx_empty));

  lvl_cross #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b1)) u_tx_af (
    .clk, .rst_n, .en(!fifo_clr), .cur_lvl(tx_level), .nxt_lvl(tx_nxt), .thr(tx_af_thr), .hit(tx_af_evt));
  lvl_cross #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b0)) u_tx_ae (
    .clk, .rst_n, .en(!fifo_clr), .cur_lvl(tx_level), .nxt_lvl(tx_nxt), .thr(tx_ae_thr), .hit(tx_ae_evt));
  lvl_cross #(.LVL_W(LVL_W), .THR_W(THR_W), .RISING(1'b1)) u_rx_af (
    .clk, .rst_n, .en(!fifo_clr), .cur_lvl(rx_level), .nxt_lvl(rx_nxt), .thr(rx_af_thr), .hit(rx_af_evt));

  assign tx_ovf_evt = fifo_wr && tx_full && !fifo_clr;
  assign rx_unf_evt = fifo_rd && rx_empty;

  always_comb begin
    evts            = '0;
    evts[EV_TX_AF]  = tx_af_evt;
    evts[EV_TX_AE]  = tx_ae_evt;
    evts[EV_RX_AF]  = rx_af_evt;
    evts[EV_TX_OVF] = tx_ovf_evt;
    evts[EV_RX_UNF] = rx_unf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat      <= '0;
      reg_rdata <= '0;
    end else begin
      stat <= (stat_rd ? '0 : stat) | evts;
      if (fifo_rd)      reg_rdata <= rx_empty ? '0 : rx_head;
      else if (stat_rd) reg_rdata <= DW'(stat);
      else if (reg_rd)  reg_rdata <= '0;
    end
  end

  assign irq = |stat;

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[EV_TX_AF] && !stat_rd) |=> stat[EV_TX_AF]);
  // R6
  af_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_af_evt |=> (stat[EV_TX_AF] && irq));
  // R5
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf_evt |=> (reg_rdata == '0 && stat[EV_RX_UNF]));
  // R4
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_evt && !tx_pop) |=> $stable(tx_level));
endmodule

// File: tb/byte_queue_pair_tb.sv
`timescale 1ns/1ps
module byte_queue_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [6:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] tx_af_thr = 6'd4, tx_ae_thr = 6'd2, rx_af_thr = 6'd3;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_head;
  logic [6:0] tx_level, rx_level;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic       irq;

  int total = 0, bad = 0;
  logic [7:0] txq[$], rxq[$];
  int m_stat = 0;
  int m_rdata = 0;

  always #4 clk = ~clk;

  byte_queue_pair u_dut (
    .clk, .rst_n, .fifo_clr, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .tx_af_thr, .tx_ae_thr, .rx_af_thr, .tx_pop, .tx_head, .tx_level,
    .rx_push, .rx_data, .rx_level, .irq);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int o, n, ev;
    ev = 0;
    if (!rst_n) begin
      txq.delete(); rxq.delete(); m_stat = 0; m_rdata = 0;
      return;
    end
    if (fifo_clr) begin
      txq.delete(); rxq.delete();
    end else begin
      o = txq.size();
      if (tx_pop && o > 0) void'(txq.pop_front());
      if (reg_wr && reg_addr == 7'h7F) begin
        if (o < 64) txq.push_back(reg_wdata); else ev |= 8;
      end
      n = txq.size();
      if (o <= int'(tx_af_thr) && n > int'(tx_af_thr)) ev |= 1;
      if (o >= int'(tx_ae_thr) && n < int'(tx_ae_thr)) ev |= 2;
      o = rxq.size();
      if (reg_rd && reg_addr == 7'h7F) begin
        if (o > 0) m_rdata = int'(rxq.pop_front());
        else begin m_rdata = 0; ev |= 16; end
      end
      if (rx_push && o < 64) rxq.push_back(rx_data);
      n = rxq.size();
      if (o <= int'(rx_af_thr) && n > int'(rx_af_thr)) ev |= 4;
    end
    if (reg_rd && reg_addr == 7'h05) begin
      m_rdata = m_stat; m_stat = 0;
    end else if (reg_rd && reg_addr != 7'h7F) m_rdata = 0;
    m_stat |= ev;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #1;
    model_step();
    chk(tag, "tx_level", int'(tx_level), txq.size());
    chk(tag, "rx_level", int'(rx_level), rxq.size());
    chk(tag, "reg_rdata", int'(reg_rdata), m_rdata);
    chk(tag, "irq", int'(irq), int'(m_stat != 0));
    if (txq.size() > 0) chk(tag, "tx_head", int'(tx_head), int'(txq[0]));
    reg_wr = 0; reg_rd = 0; tx_pop = 0; rx_push = 0; fifo_clr = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(tag);
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    reg_addr = a; reg_rd = 1; step(tag);
  endtask

  task automatic push_rx(input logic [7:0] d, input string tag);
    rx_data = d; rx_push = 1; step(tag);
  endtask

  task automatic pop_tx(input string tag);
    tx_pop = 1; step(tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    chk("R1", "reset tx_level", int'(tx_level), 0);
    chk("R1", "reset rx_level", int'(rx_level), 0);
    chk("R1", "reset rdata", int'(reg_rdata), 0);
    chk("R1", "reset irq", int'(irq), 0);

    // R2 / R6: five writes take level 4 -> 5 past limit 4
    for (int i = 0; i < 5; i++) wr(7'h7F, 8'hA0 + 8'(i), "R2");
    chk("R6", "irq after crossing", int'(irq), 1);
    rd(7'h05, "R10");
    chk("R10", "status read", int'(reg_rdata), 8'h01);
    chk("R10", "irq cleared", int'(irq), 0);

    // R9: fill to 64 without a fresh event
    for (int i = 5; i < 64; i++) wr(7'h7F, 8'(i * 3), "R9");
    chk("R9", "no repeat event", int'(irq), 0);

    // R4: two extra writes are dropped
    wr(7'h7F, 8'hEE, "R4"); wr(7'h7F, 8'hEF, "R4");
    chk("R4", "level held", int'(tx_level), 64);
    rd(7'h05, "R4");
    chk("R4", "overflow bit", int'(reg_rdata), 8'h08);

    // R2 / R7: drain all 64, crossing below 2
    for (int i = 0; i < 64; i++) pop_tx("R2");
    rd(7'h05, "R7");
    chk("R7", "almost empty bit", int'(reg_rdata), 8'h02);

    // R12: pop on empty
    pop_tx("R12"); pop_tx("R12");
    chk("R12", "tx still empty", int'(tx_level), 0);

    // R8: rx level 3 -> 4 past limit 3
    for (int i = 0; i < 4; i++) push_rx(8'h30 + 8'(i), "R8");
    rd(7'h05, "R8");
    chk("R8", "rx almost full bit", int'(reg_rdata), 8'h04);

    // R3 / R5
    for (int i = 0; i < 4; i++) begin
      rd(7'h7F, "R3");
      chk("R3", "rx byte order", int'(reg_rdata), 8'h30 + i);
    end
    rd(7'h7F, "R5");
    chk("R5", "underflow data", int'(reg_rdata), 0);
    rd(7'h05, "R5");
    chk("R5", "underflow bit", int'(reg_rdata), 8'h10);

    // R12: rx overfill
    for (int i = 0; i < 66; i++) push_rx(8'(i + 7), "R12");
    chk("R12", "rx capped", int'(rx_level), 64);
    rd(7'h05, "R12");

    // R2: push and pop together
    for (int i = 0; i < 3; i++) wr(7'h7F, 8'h50 + 8'(i), "R2");
    for (int i = 0; i < 4; i++) begin
      tx_pop = 1; wr(7'h7F, 8'h60 + 8'(i), "R2");
    end
    chk("R2", "level steady", int'(tx_level), 3);

    // R11: clear, tx 3 -> 0 must not flag almost-empty
    fifo_clr = 1; step("R11");
    chk("R11", "tx cleared", int'(tx_level), 0);
    chk("R11", "rx cleared", int'(rx_level), 0);
    chk("R11", "no event", int'(irq), 0);

    // R13
    wr(7'h10, 8'h99, "R13");
    chk("R13", "other write ignored", int'(tx_level), 0);
    push_rx(8'h11, "R13");
    rd(7'h10, "R13");
    chk("R13", "other read zero", int'(reg_rdata), 0);
    chk("R13", "rx untouched", int'(rx_level), 1);
    fifo_clr = 1; step("R11");

    // R6 boundary: limit 0, first write fires
    tx_af_thr = 6'd0; tx_ae_thr = 6'd0;
    wr(7'h7F, 8'h01, "R6");
    chk("R6", "limit zero fires", int'(irq), 1);
    pop_tx("R7");
    rd(7'h05, "R7");
    chk("R7", "limit zero never falls", int'(reg_rdata), 8'h01);

    // R10: event same cycle as status read
    rx_af_thr = 6'd0;
    rx_data = 8'h42; rx_push = 1; rd(7'h05, "R10");
    chk("R10", "old status returned", int'(reg_rdata), 0);
    chk("R10", "set wins", int'(irq), 1);
    rd(7'h05, "R10");
    chk("R10", "bit reported", int'(reg_rdata), 8'h04);
    step("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule